// File: doc/BRIEF.md
# Banked GPIO Port with Per-Line Single-Ended Drive

The block is a general-purpose I/O port of 24 lines, organised as three banks of eight. A host writes and reads byte-wide registers over a simple bus made of an address, write data, a one-cycle write strobe and combinational read data. Line `i` sits in bank `i / 8` at bit `i % 8`. Each line has an output data bit, a direction bit and a drive-style selection. Software uses the drive style to make a line drive both levels, sink only, or source only. The block's outputs are, for each pad, an output value and an output enable that feed a tri-state pad cell. A synchronised copy of each pad level is also read back.

Output data is changed by a two-byte burst. The host first writes the new values to the bank's data address and then writes a bit mask to the address just above it. Only the lines whose mask bit is 1 take the new value, so a single line can be changed without a read-modify-write. A small write sequencer tracks this burst. It has two states: `WS_IDLE` and `WS_ARMED`. A write to any bank's data address moves it to `WS_ARMED`, and it keeps the staged byte and the bank number. In `WS_ARMED`, a write to the mask address of the same bank commits the update and returns to `WS_IDLE`. Any other write also returns to `WS_IDLE` without a commit, and that other write still takes its normal effect. Cycles with no write leave the state unchanged. Each line's driver chooses one of four drive states: `DRV_OFF` (input), `DRV_PUSH`, `DRV_SINK` (open-drain) or `DRV_SOURCE` (open-source).

Top module: `gpio_od_port`

## Requirements
- R1: After reset every line is an input (`pad_oe` all 0) and `pad_out` is all 0. Reading any of the direction, style or style-enable addresses returns 0x00.
- R2: Bank b has its data byte at address 2b and its mask byte at 2b+1 (0x00..0x05). Writing the data byte and then the mask byte of the same bank, with no other write between them, changes only the data bits whose mask bit is 1. Idle cycles between the two writes are allowed.
- R3: A mask write has no effect on output data in three cases: with no data write before it, when the data write before it went to another bank, or when another write came between them.
- R4: Bank b's direction byte is at 0x10+b, and bit 1 means output. A line whose direction bit is 0 has `pad_oe` = 0 and `pad_out` equal to its data bit.
- R5: Bank b's style byte is at 0x20+2b and its style-enable byte is at 0x21+2b. An output line with style-enable 0 drives push-pull: `pad_oe` = 1 and `pad_out` = data.
- R6: An output line with style-enable 1 and style 0 is open-drain. `pad_out` = 0, and `pad_oe` = 1 exactly when data is 0.
- R7: An output line with style-enable 1 and style 1 is open-source. `pad_out` = 1, and `pad_oe` = 1 exactly when data is 1.
- R8: A read of bank b's data address returns `pad_in` bits 8b+7..8b through a two-flop synchronizer. A change on `pad_in` appears in the read data after exactly two rising clock edges.
- R9: The direction, style and style-enable bytes read back the value last written to them.
- R10: A read of the mask addresses or of any unmapped address returns 0x00. A write to an unmapped address changes no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pad_in | input | 24 | Pad levels, asynchronous |
| pad_out | output | 24 | Per-line output value to the pad |
| pad_oe | output | 24 | Per-line output enable to the pad |

## Verification
The drive logic is swept in two ways. A pseudo-random sweep loads every bank with scattered direction, style, enable and data bytes and compares all 24 line pairs with values computed from the mode rules. An exhaustive pass walks one line through all 16 combinations while its neighbours hold the complement, so a swapped bit or a bank mix-up shows up. Masked writes are tried with random data and mask pairs and with empty and full masks, which separates a correct merge from a plain overwrite or an inverted mask. Mask writes that arrive alone, arrive for the wrong bank or come after an intervening write check that the burst sequencer leaves `WS_ARMED` correctly. Pad input patterns are read at zero, one and two edges after they change, which pins the synchronizer depth.

// File: rtl/gpio_od_pkg.sv
package gpio_od_pkg;

    parameter int unsigned BANK_W = 8;

    // Burst-write sequencer states
    typedef enum logic {
        WS_IDLE,
        WS_ARMED
    } wr_state_t;

    // Per-line drive states
    typedef enum logic [1:0] {
        DRV_OFF,
        DRV_PUSH,
        DRV_SINK,
        DRV_SOURCE
    } drv_mode_t;

endpackage

// File: rtl/gpio_od_sync.sv
module gpio_od_sync #(
    parameter int unsigned WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    // Checker: count edges since reset so the depth check never looks into reset time
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (sync_out == $past(async_in, 2))); // R8

endmodule

// File: rtl/gpio_od_line_drv.sv
module gpio_od_line_drv
    import gpio_od_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_dir,
    input  logic line_en,
    input  logic line_style,
    input  logic line_dat,
    output logic line_oe,
    output logic line_out
);

    drv_mode_t mode_sel;

    always_comb begin
        if (!line_dir) begin
            mode_sel = DRV_OFF;
        end else if (!line_en) begin
            mode_sel = DRV_PUSH;
        end else if (!line_style) begin
            mode_sel = DRV_SINK;
        end else begin
            mode_sel = DRV_SOURCE;
        end
    end

    always_comb begin
        unique case (mode_sel)
            DRV_OFF: begin
                line_oe  = 1'b0;
                line_out = line_dat;
            end
            DRV_PUSH: begin
                line_oe  = 1'b1;
                line_out = line_dat;
            end
            DRV_SINK: begin
                line_oe  = ~line_dat;
                line_out = 1'b0;
            end
            DRV_SOURCE: begin
                line_oe  = line_dat;
                line_out = 1'b1;
            end
        endcase
    end

    AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !line_dir |-> !line_oe); // R4

    AST_PUSH_BOTH_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        (line_dir && !line_en) |-> (line_oe && (line_out == line_dat))); // R5

    AST_SINK_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (line_dir && line_en && !line_style) |-> !(line_oe && line_out)); // R6

    AST_SOURCE_NEVER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (line_dir && line_en && line_style) |-> !(line_oe && !line_out)); // R7

endmodule

// File: rtl/gpio_od_regs.sv
module gpio_od_regs
    import gpio_od_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 3,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_BASE = 'h00,
    parameter int unsigned DIR_BASE  = 'h10,
    parameter int unsigned STY_BASE  = 'h20
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [BANK_W-1:0]                   bus_wdata,
    input  logic                                bus_wr,
    output logic [BANK_W-1:0]                   bus_rdata,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0]    pad_sync,
    output logic [NUM_BANKS-1:0][BANK_W-1:0]    dat_q,
    output logic [NUM_BANKS-1:0][BANK_W-1:0]    dir_q,
    output logic [NUM_BANKS-1:0][BANK_W-1:0]    sty_q,
    output logic [NUM_BANKS-1:0][BANK_W-1:0]    ena_q
);

    localparam int unsigned BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    // Address decode, one hit vector per register kind
    logic [NUM_BANKS-1:0] hit_dat;
    logic [NUM_BANKS-1:0] hit_msk;
    logic [NUM_BANKS-1:0] hit_dir;
    logic [NUM_BANKS-1:0] hit_sty;
    logic [NUM_BANKS-1:0] hit_ena;

    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            hit_dat[b] = (bus_addr == ADDR_W'(DATA_BASE + 2 * b));
            hit_msk[b] = (bus_addr == ADDR_W'(DATA_BASE + 2 * b + 1));
            hit_dir[b] = (bus_addr == ADDR_W'(DIR_BASE + b));
            hit_sty[b] = (bus_addr == ADDR_W'(STY_BASE + 2 * b));
            hit_ena[b] = (bus_addr == ADDR_W'(STY_BASE + 2 * b + 1));
        end
    end

    // Burst-write sequencer
    wr_state_t         st_q, st_d;
    logic [BIDX_W-1:0] arm_bank_q, arm_bank_d;
    logic [BANK_W-1:0] stage_q, stage_d;
    logic              commit;

    always_comb begin
        st_d       = st_q;
        arm_bank_d = arm_bank_q;
        stage_d    = stage_q;
        commit     = 1'b0;
        if (bus_wr) begin
            st_d = WS_IDLE;
            unique case (st_q)
                WS_IDLE:  commit = 1'b0;
                WS_ARMED: commit = hit_msk[arm_bank_q];
            endcase
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (hit_dat[b]) begin
                    st_d       = WS_ARMED;
                    arm_bank_d = BIDX_W'(b);
                    stage_d    = bus_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= WS_IDLE;
            arm_bank_q <= '0;
            stage_q    <= '0;
        end else begin
            st_q       <= st_d;
            arm_bank_q <= arm_bank_d;
            stage_q    <= stage_d;
        end
    end

    // Register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q <= '0;
            dir_q <= '0;
            sty_q <= '0;
            ena_q <= '0;
        end else if (bus_wr) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (commit && (arm_bank_q == BIDX_W'(b))) begin
                    dat_q[b] <= (dat_q[b] & ~bus_wdata) | (stage_q & bus_wdata);
                end
                if (hit_dir[b]) dir_q[b] <= bus_wdata;
                if (hit_sty[b]) sty_q[b] <= bus_wdata;
                if (hit_ena[b]) ena_q[b] <= bus_wdata;
            end
        end
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit_dat[b]) bus_rdata = pad_sync[b];
            if (hit_dir[b]) bus_rdata = dir_q[b];
            if (hit_sty[b]) bus_rdata = sty_q[b];
            if (hit_ena[b]) bus_rdata = ena_q[b];
        end
    end

    AST_DATA_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !commit) |=> $stable(dat_q)); // R3

    AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(dat_q) && $stable(dir_q) && $stable(sty_q) && $stable(ena_q))); // R10

    AST_COMMIT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (st_q == WS_ARMED)); // R2

endmodule

// File: rtl/gpio_od_port.sv
module gpio_od_port
    import gpio_od_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 3,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_BASE = 'h00,
    parameter int unsigned DIR_BASE  = 'h10,
    parameter int unsigned STY_BASE  = 'h20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [BANK_W-1:0]             bus_wdata,
    input  logic                          bus_wr,
    output logic [BANK_W-1:0]             bus_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0]   pad_in,
    output logic [NUM_BANKS*BANK_W-1:0]   pad_out,
    output logic [NUM_BANKS*BANK_W-1:0]   pad_oe
);

    localparam int unsigned LINES = NUM_BANKS * BANK_W;

    logic [LINES-1:0]                  pad_sync;
    logic [NUM_BANKS-1:0][BANK_W-1:0]  dat_q;
    logic [NUM_BANKS-1:0][BANK_W-1:0]  dir_q;
    logic [NUM_BANKS-1:0][BANK_W-1:0]  sty_q;
    logic [NUM_BANKS-1:0][BANK_W-1:0]  ena_q;
    logic [LINES-1:0]                  line_dat;
    logic [LINES-1:0]                  line_dir;
    logic [LINES-1:0]                  line_sty;
    logic [LINES-1:0]                  line_ena;

    gpio_od_sync #(
        .WIDTH (LINES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    gpio_od_regs #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .DATA_BASE (DATA_BASE),
        .DIR_BASE  (DIR_BASE),
        .STY_BASE  (STY_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rdata (bus_rdata),
        .pad_sync  (pad_sync),
        .dat_q     (dat_q),
        .dir_q     (dir_q),
        .sty_q     (sty_q),
        .ena_q     (ena_q)
    );

    assign line_dat = dat_q;
    assign line_dir = dir_q;
    assign line_sty = sty_q;
    assign line_ena = ena_q;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        gpio_od_line_drv u_drv (
            .clk        (clk),
            .rst_n      (rst_n),
            .line_dir   (line_dir[i]),
            .line_en    (line_ena[i]),
            .line_style (line_sty[i]),
            .line_dat   (line_dat[i]),
            .line_oe    (pad_oe[i]),
            .line_out   (pad_out[i])
        );
    end

endmodule

// File: tb/gpio_od_port_tb_top.sv
`timescale 1ns/1ps
module gpio_od_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic [23:0] pad_in = 24'h0;
    logic [23:0] pad_out;
    logic [23:0] pad_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0]  e_dat [3];
    logic [7:0]  e_dir [3];
    logic [7:0]  e_sty [3];
    logic [7:0]  e_ena [3];
    logic [15:0] seed = 16'h1d3b;

    always #4 clk = ~clk;

    gpio_od_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] nx();
        seed = seed * 16'd25173 + 16'd13849;
        return seed[15:8];
    endfunction

    task automatic bwr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic brd(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic set_data(input int b, input logic [7:0] d, input logic [7:0] m);
        bwr(8'(2 * b), d);
        bwr(8'(2 * b + 1), m);
        e_dat[b] = (e_dat[b] & ~m) | (d & m);
    endtask

    task automatic set_cfg(input int b, input logic [7:0] dv, input logic [7:0] sv, input logic [7:0] ev);
        bwr(8'(8'h10 + b), dv);
        bwr(8'(8'h20 + 2 * b), sv);
        bwr(8'(8'h21 + 2 * b), ev);
        e_dir[b] = dv;
        e_sty[b] = sv;
        e_ena[b] = ev;
    endtask

    task automatic chk_lines();
        for (int i = 0; i < 24; i++) begin
            logic d, r, s, e, xo, xe;
            string tag;
            d = e_dat[i / 8][i % 8];
            r = e_dir[i / 8][i % 8];
            s = e_sty[i / 8][i % 8];
            e = e_ena[i / 8][i % 8];
            if (!r) begin
                tag = "R4"; xe = 1'b0; xo = d;
            end else if (!e) begin
                tag = "R5"; xe = 1'b1; xo = d;
            end else if (!s) begin
                tag = "R6"; xe = ~d; xo = 1'b0;
            end else begin
                tag = "R7"; xe = d; xo = 1'b1;
            end
            chk({tag, $sformatf(" line %0d oe", i)}, 32'(pad_oe[i]), 32'(xe));
            chk({tag, $sformatf(" line %0d out", i)}, 32'(pad_out[i]), 32'(xo));
        end
    endtask

    task automatic chk_readback(input string tag);
        logic [7:0] v;
        for (int b = 0; b < 3; b++) begin
            brd(8'(8'h10 + b), v);      chk({tag, " dir"}, 32'(v), 32'(e_dir[b]));
            brd(8'(8'h20 + 2 * b), v);  chk({tag, " style"}, 32'(v), 32'(e_sty[b]));
            brd(8'(8'h21 + 2 * b), v);  chk({tag, " enable"}, 32'(v), 32'(e_ena[b]));
        end
    endtask

    initial begin
        logic [7:0] v;
        logic [23:0] pat;
        logic [23:0] old_pat;
        for (int b = 0; b < 3; b++) begin
            e_dat[b] = 8'h00; e_dir[b] = 8'h00; e_sty[b] = 8'h00; e_ena[b] = 8'h00;
        end
        pad_in = 24'h5a5a5a;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pad_oe", 32'(pad_oe), 32'h0);
        chk("R1 pad_out", 32'(pad_out), 32'h0);
        chk_readback("R1");

        // R5/R6/R7/R4 pseudo-random sweep over all banks
        for (int it = 0; it < 32; it++) begin
            for (int b = 0; b < 3; b++) begin
                set_cfg(b, nx(), nx(), nx());
                set_data(b, nx(), 8'hff);
            end
            chk_lines();
        end
        chk_readback("R9");

        // Exhaustive modes on line 13 with complemented neighbours
        for (int c = 0; c < 16; c++) begin
            logic [7:0] bitm;
            bitm = 8'h20;
            set_cfg(1, c[0] ? bitm : ~bitm, c[1] ? bitm : ~bitm, c[2] ? bitm : ~bitm);
            set_data(1, c[3] ? bitm : ~bitm, 8'hff);
            chk_lines();
        end

        // R2 masked data writes, all lines push-pull outputs
        for (int b = 0; b < 3; b++) set_cfg(b, 8'hff, 8'h00, 8'h00);
        for (int b = 0; b < 3; b++) begin
            set_data(b, 8'h00, 8'hff);
            chk("R2 full mask clear", 32'(pad_out[b * 8 +: 8]), 32'(e_dat[b]));
            set_data(b, 8'hff, 8'h00);
            chk("R2 empty mask", 32'(pad_out[b * 8 +: 8]), 32'(e_dat[b]));
            for (int k = 0; k < 12; k++) begin
                set_data(b, nx(), nx());
                chk($sformatf("R2 bank %0d", b), 32'(pad_out), 32'({e_dat[2], e_dat[1], e_dat[0]}));
            end
        end

        // R3 mask writes without a valid preceding data write
        set_data(0, 8'h3c, 8'hff);
        set_data(1, 8'hc3, 8'hff);
        bwr(8'h01, 8'hff);
        chk("R3 lone mask", 32'(pad_out), 32'({e_dat[2], e_dat[1], e_dat[0]}));
        bwr(8'h00, 8'haa);
        bwr(8'h03, 8'hff);
        chk("R3 wrong bank", 32'(pad_out), 32'({e_dat[2], e_dat[1], e_dat[0]}));
        bwr(8'h00, 8'h55);
        bwr(8'h10, 8'hff);
        bwr(8'h01, 8'hff);
        chk("R3 intervening write", 32'(pad_out), 32'({e_dat[2], e_dat[1], e_dat[0]}));
        bwr(8'h01, 8'hff);
        chk("R3 repeated mask", 32'(pad_out), 32'({e_dat[2], e_dat[1], e_dat[0]}));
        bwr(8'h02, 8'h0f);
        @(negedge clk);
        @(negedge clk);
        bwr(8'h03, 8'hf0);
        e_dat[1] = (e_dat[1] & 8'h0f);
        chk("R2 idle gap burst", 32'(pad_out), 32'({e_dat[2], e_dat[1], e_dat[0]}));

        // R10 unmapped writes and reads
        bwr(8'h04, 8'h77);
        for (int k = 0; k < 6; k++) begin
            logic [7:0] ua;
            ua = (k == 0) ? 8'h06 : (k == 1) ? 8'h13 : (k == 2) ? 8'h26 :
                 (k == 3) ? 8'h27 : (k == 4) ? 8'h80 : 8'hff;
            bwr(ua, 8'hff);
        end
        bwr(8'h05, 8'hff);
        chk("R10 unmapped writes", 32'(pad_out), 32'({e_dat[2], e_dat[1], e_dat[0]}));
        chk("R10 unmapped writes oe", 32'(pad_oe), 32'hffffff);
        chk_readback("R10");
        for (int k = 0; k < 7; k++) begin
            logic [7:0] ua;
            ua = (k == 0) ? 8'h01 : (k == 1) ? 8'h03 : (k == 2) ? 8'h05 : (k == 3) ? 8'h06 :
                 (k == 4) ? 8'h13 : (k == 5) ? 8'h26 : 8'hff;
            brd(ua, v);
            chk($sformatf("R10 read %0h", ua), 32'(v), 32'h0);
        end

        // R8 pad input readback through two flops
        @(negedge clk);
        @(negedge clk);
        old_pat = 24'h5a5a5a;
        for (int k = 0; k < 8; k++) begin
            pat = (k == 0) ? 24'h000000 : (k == 1) ? 24'hffffff : {nx(), nx(), nx()};
            pad_in = pat;
            for (int b = 0; b < 3; b++) begin
                brd(8'(2 * b), v);
                chk("R8 zero edges", 32'(v), 32'(old_pat[b * 8 +: 8]));
            end
            @(negedge clk);
            for (int b = 0; b < 3; b++) begin
                brd(8'(2 * b), v);
                chk("R8 one edge", 32'(v), 32'(old_pat[b * 8 +: 8]));
            end
            @(negedge clk);
            for (int b = 0; b < 3; b++) begin
                brd(8'(2 * b), v);
                chk("R8 two edges", 32'(v), 32'(pat[b * 8 +: 8]));
            end
            old_pat = pat;
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule